// File: doc/BRIEF.md
# Stochastic Variable Node with Edge Memories

This block is one variable node of a fully parallel stochastic LDPC decoder. Each clock is one decoding cycle. In each cycle the node takes one bit from the channel stream and one bit from each connected check node. It then returns one bit per edge. The bit for an edge is formed from the channel bit and the bits of all other active edges. That edge's own incoming bit is always left out. The operands pass through a cascade of two-input equality elements. If every operand agrees, the update succeeds: the common value is emitted and pushed into that edge's memory.

If any pair of operands disagrees, the edge is in the hold state. Instead of latching its previous output, the edge replays a bit from its own edge memory. The edge memory is a shift register of recent successful outputs, and the bit is picked by a random address supplied on an input port. This keeps the node from locking up when the streams rarely switch.

The node degree is chosen at run time from 1 to `MAX_DEG`. Edges at or above the selected degree are switched off.

Top module: `svn_node`

## Requirements
- R1: Synchronous active-high reset drives every edge output to 0 and clears every edge memory to all zeros. After reset, a hold state on any edge returns 0 whatever the address.
- R2: The effective degree is `deg_sel`, clamped to the range 1 to `MAX_DEG`. A value of 0 acts as 1, and a value above `MAX_DEG` acts as `MAX_DEG`.
- R3: Edge e is active only when e is less than the effective degree. An inactive edge outputs 0 and its memory is left unchanged.
- R4: The operands of active edge e are `chan_bit` plus `cn_in[j]` for every active j other than e. The edge's own `cn_in[e]` never affects `edge_out[e]`.
- R5: When all operands of an active edge are equal, `edge_out[e]` takes that common value on the next clock edge. Outputs are registered, with one clock of latency.
- R6: When any operands of an active edge differ, `edge_out[e]` takes, on the next clock edge, bit `rand_addr[e*ADDR_W +: ADDR_W]` of that edge's memory. Index 0 holds the most recent successful output.
- R7: A successful update shifts the new bit into index 0 and moves every older bit up by one index. A hold leaves the memory unchanged.
- R8: With effective degree 1, edge 0 has only the channel operand, so `edge_out[0]` repeats `chan_bit` one clock later.
- R9: The memory holds `EM_DEPTH` (64) bits. A bit written k successful updates ago is read at address k, for k up to 63. Older bits are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one decoding cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| deg_sel | input | DEG_W (3) | Requested node degree, clamped to 1..MAX_DEG |
| chan_bit | input | 1 | Channel stochastic stream bit |
| cn_in | input | MAX_DEG (6) | Incoming check-node bits, one per edge |
| rand_addr | input | MAX_DEG*ADDR_W (36) | Random edge-memory read address, ADDR_W bits per edge |
| edge_out | output | MAX_DEG (6) | Registered outgoing bits, one per edge |

## Verification
The bench builds the node with its defaults: six edges and 64-entry memories. This allows every degree from 1 to 6 to be selected at run time. It also lets the out-of-range selections 0 and 7 be driven on the 3-bit selector to exercise the clamp.

The 64-deep memory is filled through 64 and then 65 successful updates. Reading addresses 0 and 63 then shows both ends of the shift register and the loss of the oldest bit. Random streams are biased toward agreement, so that at degree 6 both the update and the hold paths occur often.

// File: rtl/svn_pkg.sv
`timescale 1ns/1ps
package svn_pkg;
    localparam int SVN_MAX_DEG  = 6;
    localparam int SVN_EM_DEPTH = 64;

    // Token travelling down an equality cascade: ok = all operands agreed so far
    typedef struct packed {
        logic ok;
        logic val;
    } eq_tok_t;

    function automatic eq_tok_t eq_merge(input eq_tok_t a, input logic b);
        eq_tok_t r;
        r.ok  = a.ok && (a.val == b);
        r.val = a.val;
        return r;
    endfunction

    function automatic eq_tok_t eq_seed(input logic b);
        eq_tok_t r;
        r.ok  = 1'b1;
        r.val = b;
        return r;
    endfunction
endpackage

// File: rtl/svn_deg_ctrl.sv
`timescale 1ns/1ps
module svn_deg_ctrl #(
    parameter int MAX_DEG = svn_pkg::SVN_MAX_DEG,
    parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
    input  logic [DEG_W-1:0]   deg_sel,
    output logic [MAX_DEG-1:0] edge_en
);
    logic [DEG_W-1:0] deg_eff;

    always_comb begin
        if (deg_sel == '0)
            deg_eff = DEG_W'(1);
        else if (int'(deg_sel) > MAX_DEG)
            deg_eff = DEG_W'(MAX_DEG);
        else
            deg_eff = deg_sel;
        for (int i = 0; i < MAX_DEG; i++)
            edge_en[i] = (int'(deg_eff) > i);
    end

    // R2 / R3: edge 0 is always on and enables form a contiguous run from bit 0
    always_comb begin
        edge0_on_chk: assert (edge_en[0]);
        contig_en_chk: assert ((edge_en & (edge_en + 1'b1)) == '0);
    end
endmodule

// File: rtl/svn_eq_chain.sv
`timescale 1ns/1ps
module svn_eq_chain
    import svn_pkg::*;
#(
    parameter int MAX_DEG = svn_pkg::SVN_MAX_DEG
) (
    input  logic               chan_bit,
    input  logic [MAX_DEG-1:0] op_bits,
    input  logic [MAX_DEG-1:0] op_en,
    output eq_tok_t            result
);
    eq_tok_t stage [MAX_DEG+1];

    assign stage[0] = eq_seed(chan_bit);

    for (genvar j = 0; j < MAX_DEG; j++) begin : g_stage
        assign stage[j+1] = op_en[j] ? eq_merge(stage[j], op_bits[j]) : stage[j];
    end

    assign result = stage[MAX_DEG];
endmodule

// File: rtl/svn_edge_mem.sv
`timescale 1ns/1ps
module svn_edge_mem
    import svn_pkg::*;
#(
    parameter int EM_DEPTH = svn_pkg::SVN_EM_DEPTH,
    parameter int ADDR_W   = $clog2(EM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_on,
    input  eq_tok_t           tok,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              out_bit
);
    logic [EM_DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem     <= '0;
            out_bit <= 1'b0;
        end else if (!edge_on) begin
            out_bit <= 1'b0;
        end else if (tok.ok) begin
            mem     <= {mem[EM_DEPTH-2:0], tok.val};
            out_bit <= tok.val;
        end else begin
            out_bit <= mem[rd_addr];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_bit == 1'b0) && (mem == '0));
    // R3
    idle_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_on |=> !out_bit && $stable(mem));
    // R5
    update_out_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_on && tok.ok) |=> out_bit == $past(tok.val));
    // R7
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_on && tok.ok) |=> mem[0] == $past(tok.val));
    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_on && !tok.ok) |=> $stable(mem));
endmodule

// File: rtl/svn_node.sv
`timescale 1ns/1ps
module svn_node
    import svn_pkg::*;
#(
    parameter int MAX_DEG  = svn_pkg::SVN_MAX_DEG,
    parameter int EM_DEPTH = svn_pkg::SVN_EM_DEPTH,
    localparam int ADDR_W  = $clog2(EM_DEPTH),
    localparam int DEG_W   = $clog2(MAX_DEG + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEG_W-1:0]          deg_sel,
    input  logic                      chan_bit,
    input  logic [MAX_DEG-1:0]        cn_in,
    input  logic [MAX_DEG*ADDR_W-1:0] rand_addr,
    output logic [MAX_DEG-1:0]        edge_out
);
    logic [MAX_DEG-1:0] edge_en;

    svn_deg_ctrl #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_deg (
        .deg_sel (deg_sel),
        .edge_en (edge_en)
    );

    for (genvar e = 0; e < MAX_DEG; e++) begin : g_edge
        localparam logic [MAX_DEG-1:0] SELF = MAX_DEG'(1) << e;
        logic [MAX_DEG-1:0] op_en;
        eq_tok_t            tok;

        // exclude this edge's own input from its operand set
        assign op_en = edge_en & ~SELF;

        svn_eq_chain #(.MAX_DEG(MAX_DEG)) u_chain (
            .chan_bit (chan_bit),
            .op_bits  (cn_in),
            .op_en    (op_en),
            .result   (tok)
        );

        svn_edge_mem #(.EM_DEPTH(EM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
            .clk     (clk),
            .rst     (rst),
            .edge_on (edge_en[e]),
            .tok     (tok),
            .rd_addr (rand_addr[e*ADDR_W +: ADDR_W]),
            .out_bit (edge_out[e])
        );
    end

    // R8 (with R2: a selector of 0 behaves as degree 1)
    deg_one_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(deg_sel) <= 1) |=> (edge_out[0] == $past(chan_bit)) &&
                                 (edge_out[MAX_DEG-1:1] == '0));
endmodule

// File: tb/svn_node_test.sv
`timescale 1ns/1ps
module svn_node_test;
    localparam int MD = 6;
    localparam int DP = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    deg_sel;
    logic          chan_bit;
    logic [MD-1:0] cn_in;
    logic [MD*AW-1:0] rand_addr;
    logic [MD-1:0] edge_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DP-1:0] mm [MD];

    always #2.5 clk = ~clk;

    svn_node uut (
        .clk(clk), .rst(rst), .deg_sel(deg_sel), .chan_bit(chan_bit),
        .cn_in(cn_in), .rand_addr(rand_addr), .edge_out(edge_out)
    );

    function automatic int eff_deg(input logic [2:0] d);
        if (d == 0) return 1;
        if (int'(d) > MD) return MD;
        return int'(d);
    endfunction

    task automatic check_bit(input int e, input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %b expected %b", req, e, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] d, input logic c, input logic [MD-1:0] cn,
                        input logic [MD*AW-1:0] ad, input string note);
        logic [MD-1:0] exp;
        string tags [MD];
        int de;
        deg_sel = d; chan_bit = c; cn_in = cn; rand_addr = ad;
        de = eff_deg(d);
        for (int e = 0; e < MD; e++) begin
            if (e >= de) begin
                exp[e] = 1'b0; tags[e] = "R3";
            end else begin
                logic ok;
                ok = 1'b1;
                for (int j = 0; j < de; j++)
                    if (j != e && cn[j] != c) ok = 1'b0;
                if (ok) begin
                    exp[e] = c; mm[e] = {mm[e][DP-2:0], c}; tags[e] = "R5";
                end else begin
                    exp[e] = mm[e][ad[e*AW +: AW]]; tags[e] = "R6";
                end
            end
        end
        @(posedge clk); #1;
        for (int e = 0; e < MD; e++)
            check_bit(e, edge_out[e], exp[e], {tags[e], note});
    endtask

    function automatic logic [MD*AW-1:0] rnd_addr();
        logic [MD*AW-1:0] a;
        for (int e = 0; e < MD; e++) a[e*AW +: AW] = AW'($urandom % DP);
        return a;
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; deg_sel = 3'd6; chan_bit = 1'b1; cn_in = '1; rand_addr = '0;
        for (int e = 0; e < MD; e++) mm[e] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low while in reset
        for (int e = 0; e < MD; e++) check_bit(e, edge_out[e], 1'b0, "R1 reset");
        rst = 1'b0;

        // R1: cleared memories read 0 under hold at any address
        for (int k = 0; k < 8; k++)
            step(3'd6, 1'b1, 6'b010101, rnd_addr(), " R1 post-reset hold");

        // R8: degree 1 follows the channel
        for (int k = 0; k < 20; k++)
            step(3'd1, 1'($urandom % 2), 6'($urandom), rnd_addr(), " R8 deg1");
        // R2: selector 0 acts as 1, selector 7 acts as 6
        for (int k = 0; k < 20; k++)
            step(3'd0, 1'($urandom % 2), 6'($urandom), rnd_addr(), " R2 deg0");
        for (int k = 0; k < 20; k++)
            step(3'd7, 1'($urandom % 2), 6'($urandom), rnd_addr(), " R2 deg7");

        // R4: edge 0's own input disagrees, others agree -> edge 0 updates, 1 and 2 hold
        step(3'd3, 1'b1, 6'b000110, rnd_addr(), " R4 own-excluded");
        step(3'd3, 1'b0, 6'b000001, rnd_addr(), " R4 own-excluded");

        // R9/R7: push 65 known bits into edges 0,1 at degree 2, then read both ends
        for (int k = 0; k < DP + 1; k++) begin
            logic b;
            b = 1'(k % 3 == 0);
            step(3'd2, b, {4'b0, b, b}, rnd_addr(), " R7 fill");
        end
        step(3'd2, 1'b1, 6'b000000, {24'd0, 6'd63, 6'd63}, " R9 addr63");
        step(3'd2, 1'b1, 6'b000000, {24'd0, 6'd0, 6'd0}, " R9 addr0");
        step(3'd2, 1'b0, 6'b000011, {24'd0, 6'd62, 6'd1}, " R7 hold unchanged");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic base;
            logic [MD-1:0] cn;
            logic c;
            base = 1'($urandom % 2);
            c = base ^ 1'($urandom % 8 == 0);
            for (int j = 0; j < MD; j++) cn[j] = base ^ 1'($urandom % 8 == 0);
            step(3'($urandom % 8), c, cn, rnd_addr(), " random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule